// File: doc/BRIEF.md
# Mask-Compare Address Region Decoder

This block maps a physical address onto one of a small set of programmable regions. Each region stores a mask, a compare value, a valid bit, a memory-controller flag, a signed chip-select index and signed read and write wait counts. A lookup is combinational. In the same cycle as the address it returns whether a region matched, which region matched, the chip select and the wait count of that region for the requested direction, and whether that direction is permitted. An access that matches no region raises a bus error.

Matching follows a fixed order. The single region flagged as the memory controller's region is tested first, whether or not it is valid. Next comes a one-entry record of the region that hit most recently, also tested without the valid bit. Last, the table is scanned from index 0 upward, and only valid entries count. Regions are programmed through a single-cycle configuration write port that has four operations. Overlap between regions is not checked, and no data moves through the block.

Top module: `region_decoder`

## Requirements
- R1: A region matches when (addr_i AND mask) equals (compare AND mask). hit_o and idx_o reflect addr_i combinationally, in the same cycle.
- R2: A configuration write with cfg_op_i=0 (load) rounds cfg_size_i up to the next power of two P, sets mask = NOT(P-1) and sets compare = cfg_base_i AND mask. The region then covers exactly the aligned P-byte block that holds the base.
- R3: A load also sets the region valid, sets both wait counts to 2 and sets its chip select to -1 (all ones). The memory-controller flag is left as it was.
- R4: cfg_op_i=3 with cfg_flag_i=1 makes region cfg_idx_i the only memory-controller region and clears the flag from every other region. With cfg_flag_i=0 it clears the flag of that region. The memory-controller region wins whenever it matches, even when it is invalid and other regions also match.
- R5: When the memory-controller region does not match, the most recently hit region is tested next. It wins if it matches, even if it is no longer valid.
- R6: Otherwise the table is scanned in ascending index order, and only entries whose valid bit is set may match. cfg_op_i=2 writes cfg_flag_i into the valid bit.
- R7: When req_i is high and nothing matches, bus_err_o is 1, hit_o is 0, and idx_o, cs_o, wait_o and deny_o are 0.
- R8: On a clock edge where req_i is high, the last-hit record takes the matched index on a hit and is cleared on a miss. Without req_i it holds its value.
- R9: cfg_op_i=1 writes the read wait, the write wait and the chip select of a region. On a hit, cs_o is the chip select of the winning region, and wait_o is its read wait when rd_i=1 or its write wait when rd_i=0.
- R10: deny_o is 1 on a hit whose selected wait count is negative. This means a read returns zero or a write is dropped.
- R11: After reset all regions are invalid with mask all ones, compare 0 and no memory-controller flag, and the last-hit record is empty. A configuration write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 0 load, 1 timing, 2 valid, 3 memory-controller flag |
| cfg_idx_i | input | IDX_W | Region being written |
| cfg_base_i | input | ADDR_W | Base address for load |
| cfg_size_i | input | ADDR_W | Size in bytes for load |
| cfg_rd_wait_i | input | WAIT_W | Signed read wait for timing |
| cfg_wr_wait_i | input | WAIT_W | Signed write wait for timing |
| cfg_cs_i | input | CS_W | Signed chip select for timing |
| cfg_flag_i | input | 1 | Bit for the valid and memory-controller operations |
| req_i | input | 1 | Lookup request |
| rd_i | input | 1 | 1 read, 0 write |
| addr_i | input | ADDR_W | Lookup address |
| hit_o | output | 1 | A region matched |
| idx_o | output | IDX_W | Winning region |
| bus_err_o | output | 1 | Request with no match |
| cs_o | output | CS_W | Chip select of the winning region |
| wait_o | output | WAIT_W | Wait count for the requested direction |
| deny_o | output | 1 | Requested direction not permitted |

## Verification
Every lookup result is combinational, so the result for an address is due in the cycle that address is presented. The bench drives each request on the falling edge and compares the result a quarter period later, before the next rising edge. The last-hit record and configuration writes take effect on the rising edge that follows, so the bench's reference model applies them only after that edge. Accesses are chosen so that each priority stage in turn decides the winner: overlapping regions, an invalid region still held as the last hit, and a memory-controller region that is invalid.

// File: rtl/region_pkg.sv
package region_pkg;
  parameter int DEFAULT_WAIT = 2;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_TIMING = 2'd1,
    OP_VALID  = 2'd2,
    OP_MC     = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/region_table.sv
module region_table
  import region_pkg::*;
#(
  parameter int N_REG  = 8,
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 8,
  parameter int CS_W   = 4,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_op_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic [ADDR_W-1:0]        cfg_base_i,
  input  logic [ADDR_W-1:0]        cfg_size_i,
  input  logic signed [WAIT_W-1:0] cfg_rd_wait_i,
  input  logic signed [WAIT_W-1:0] cfg_wr_wait_i,
  input  logic signed [CS_W-1:0]   cfg_cs_i,
  input  logic                     cfg_flag_i,
  output logic [ADDR_W-1:0]        mask_o    [N_REG],
  output logic [ADDR_W-1:0]        cmp_o     [N_REG],
  output logic [N_REG-1:0]         valid_o,
  output logic [N_REG-1:0]         mc_o,
  output logic signed [WAIT_W-1:0] rd_wait_o [N_REG],
  output logic signed [WAIT_W-1:0] wr_wait_o [N_REG],
  output logic signed [CS_W-1:0]   cs_o      [N_REG]
);
  logic [ADDR_W-1:0] load_mask;
  logic [ADDR_W-1:0] smear;
  logic [N_REG-1:0]  idx_bit;

  // smear (size-1) right so every bit below the top one is set
  always_comb begin
    smear = cfg_size_i - ADDR_W'(1);
    for (int s = 1; s < ADDR_W; s = s * 2) smear = smear | (smear >> s);
    load_mask = ~smear;
  end

  assign idx_bit = N_REG'(1) << cfg_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REG; i++) begin
        mask_o[i]    <= '1;
        cmp_o[i]     <= '0;
        rd_wait_o[i] <= WAIT_W'(DEFAULT_WAIT);
        wr_wait_o[i] <= WAIT_W'(DEFAULT_WAIT);
        cs_o[i]      <= '1;
      end
      valid_o <= '0;
      mc_o    <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_op_e'(cfg_op_i))
        OP_LOAD: begin
          mask_o[cfg_idx_i]    <= load_mask;
          cmp_o[cfg_idx_i]     <= cfg_base_i & load_mask;
          valid_o[cfg_idx_i]   <= 1'b1;
          rd_wait_o[cfg_idx_i] <= WAIT_W'(DEFAULT_WAIT);
          wr_wait_o[cfg_idx_i] <= WAIT_W'(DEFAULT_WAIT);
          cs_o[cfg_idx_i]      <= '1;
        end
        OP_TIMING: begin
          rd_wait_o[cfg_idx_i] <= cfg_rd_wait_i;
          wr_wait_o[cfg_idx_i] <= cfg_wr_wait_i;
          cs_o[cfg_idx_i]      <= cfg_cs_i;
        end
        OP_VALID: valid_o[cfg_idx_i] <= cfg_flag_i;
        OP_MC:    mc_o <= cfg_flag_i ? idx_bit : (mc_o & ~idx_bit);
        default: ;
      endcase
    end
  end

  AST_MC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mc_o)); // R4

  AST_LOAD_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i == 2'd0) |=>
      (rd_wait_o[$past(cfg_idx_i)] == WAIT_W'(DEFAULT_WAIT)) &&
      (wr_wait_o[$past(cfg_idx_i)] == WAIT_W'(DEFAULT_WAIT)) &&
      valid_o[$past(cfg_idx_i)]); // R3
endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int N_REG  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i [N_REG],
  input  logic [ADDR_W-1:0] cmp_i  [N_REG],
  output logic [N_REG-1:0]  match_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    assign match_o[g] = ((addr_i & mask_i[g]) == (cmp_i[g] & mask_i[g]));
  end
endmodule

// File: rtl/region_pick.sv
module region_pick #(
  parameter int N_REG = 8,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic [N_REG-1:0] match_i,
  input  logic [N_REG-1:0] valid_i,
  input  logic [N_REG-1:0] mc_i,
  input  logic             last_vld_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_REG-1:0] mc_hit_vec, tab_vec;
  logic [IDX_W-1:0] mc_idx, tab_idx;
  logic             last_ok;

  assign mc_hit_vec = match_i & mc_i;
  assign tab_vec    = match_i & valid_i;
  assign last_ok    = last_vld_i && match_i[last_idx_i];

  // downward scan so the lowest set index is left standing
  always_comb begin
    mc_idx  = '0;
    tab_idx = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (mc_hit_vec[i]) mc_idx = IDX_W'(i);
      if (tab_vec[i])    tab_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (|mc_hit_vec) begin
      hit_o = 1'b1;
      idx_o = mc_idx;
    end else if (last_ok) begin
      hit_o = 1'b1;
      idx_o = last_idx_i;
    end else begin
      hit_o = |tab_vec;
      idx_o = tab_idx;
    end
  end
endmodule

// File: rtl/region_decoder.sv
module region_decoder
  import region_pkg::*;
#(
  parameter int N_REG  = 8,
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 8,
  parameter int CS_W   = 4,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_op_i,
  input  logic [IDX_W-1:0]         cfg_idx_i,
  input  logic [ADDR_W-1:0]        cfg_base_i,
  input  logic [ADDR_W-1:0]        cfg_size_i,
  input  logic signed [WAIT_W-1:0] cfg_rd_wait_i,
  input  logic signed [WAIT_W-1:0] cfg_wr_wait_i,
  input  logic signed [CS_W-1:0]   cfg_cs_i,
  input  logic                     cfg_flag_i,
  input  logic                     req_i,
  input  logic                     rd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic                     bus_err_o,
  output logic signed [CS_W-1:0]   cs_o,
  output logic signed [WAIT_W-1:0] wait_o,
  output logic                     deny_o
);
  logic [ADDR_W-1:0]        mask_arr [N_REG];
  logic [ADDR_W-1:0]        cmp_arr  [N_REG];
  logic signed [WAIT_W-1:0] rdw_arr  [N_REG];
  logic signed [WAIT_W-1:0] wrw_arr  [N_REG];
  logic signed [CS_W-1:0]   cs_arr   [N_REG];
  logic [N_REG-1:0]         valid_vec, mc_vec, match_vec;
  logic                     pick_hit;
  logic [IDX_W-1:0]         pick_idx;
  logic                     last_vld;
  logic [IDX_W-1:0]         last_idx;
  logic signed [WAIT_W-1:0] sel_wait;

  region_table #(
    .N_REG(N_REG), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CS_W(CS_W)
  ) u_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_op_i, .cfg_idx_i, .cfg_base_i,
    .cfg_size_i, .cfg_rd_wait_i, .cfg_wr_wait_i, .cfg_cs_i, .cfg_flag_i,
    .mask_o(mask_arr), .cmp_o(cmp_arr), .valid_o(valid_vec), .mc_o(mc_vec),
    .rd_wait_o(rdw_arr), .wr_wait_o(wrw_arr), .cs_o(cs_arr)
  );

  region_match #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_match (
    .addr_i, .mask_i(mask_arr), .cmp_i(cmp_arr), .match_o(match_vec)
  );

  region_pick #(.N_REG(N_REG)) u_pick (
    .match_i(match_vec), .valid_i(valid_vec), .mc_i(mc_vec),
    .last_vld_i(last_vld), .last_idx_i(last_idx),
    .hit_o(pick_hit), .idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld <= 1'b0;
      last_idx <= '0;
    end else if (req_i) begin
      last_vld <= pick_hit;
      last_idx <= pick_hit ? pick_idx : '0;
    end
  end

  assign sel_wait  = rd_i ? rdw_arr[pick_idx] : wrw_arr[pick_idx];
  assign hit_o     = pick_hit;
  assign idx_o     = pick_hit ? pick_idx : '0;
  assign bus_err_o = req_i && !pick_hit;
  assign cs_o      = pick_hit ? cs_arr[pick_idx] : '0;
  assign wait_o    = pick_hit ? sel_wait : '0;
  assign deny_o    = pick_hit && sel_wait[WAIT_W-1];

  AST_PICK_IS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_vec[idx_o]); // R1

  AST_MC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(match_vec & mc_vec)) |-> (hit_o && mc_vec[idx_o])); // R4

  AST_TABLE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !mc_vec[idx_o] && !(last_vld && last_idx == idx_o))
      |-> valid_vec[idx_o]); // R6

  AST_MISS_CLEARS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit_o) |=> !last_vld); // R8

  AST_HIT_RECORDS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit_o) |=> (last_vld && last_idx == $past(idx_o))); // R8

  AST_DENY_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> hit_o); // R10
endmodule

// File: tb/tb_region_decoder.sv
`timescale 1ns/1ps
module tb_region_decoder;
  localparam int N = 8;
  localparam int AW = 32;
  localparam int WW = 8;
  localparam int CW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0, cfg_size = '0;
  logic signed [WW-1:0] cfg_rdw = '0, cfg_wrw = '0;
  logic signed [CW-1:0] cfg_cs = '0;
  logic cfg_flag = 1'b0;
  logic req = 1'b0, rd = 1'b1;
  logic [AW-1:0] addr = '0;
  logic hit, berr, deny;
  logic [IW-1:0] idx;
  logic signed [CW-1:0] cs;
  logic signed [WW-1:0] wt;

  always #4 clk = ~clk;

  region_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_op_i(cfg_op),
    .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size),
    .cfg_rd_wait_i(cfg_rdw), .cfg_wr_wait_i(cfg_wrw), .cfg_cs_i(cfg_cs),
    .cfg_flag_i(cfg_flag), .req_i(req), .rd_i(rd), .addr_i(addr),
    .hit_o(hit), .idx_o(idx), .bus_err_o(berr), .cs_o(cs), .wait_o(wt),
    .deny_o(deny)
  );

  int total = 0, bad = 0;

  // reference model
  logic [AW-1:0] m_mask [N];
  logic [AW-1:0] m_cmp  [N];
  bit m_valid [N];
  bit m_mc    [N];
  int m_rw [N], m_ww [N], m_cs [N];
  bit m_last_v = 0;
  int m_last_i = 0;

  typedef struct {
    string tag;
    bit    hit;
    int    idx;
    bit    err;
    int    cs;
    int    wt;
    bit    deny;
  } exp_t;
  exp_t sb[$];
  event mon_ev;

  function automatic bit m_match(int i, logic [AW-1:0] a);
    return (a & m_mask[i]) == (m_cmp[i] & m_mask[i]);
  endfunction

  function automatic int m_pick(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_mc[i] && m_match(i, a)) return i;
    if (m_last_v && m_match(m_last_i, a)) return m_last_i;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_match(i, a)) return i;
    return -1;
  endfunction

  task automatic cfg(input int op, input int i, input logic [AW-1:0] b,
                     input logic [AW-1:0] s, input int rw, input int ww,
                     input int c, input bit f);
    logic [AW-1:0] p;
    @(negedge clk);
    cfg_we = 1; cfg_op = 2'(op); cfg_idx = IW'(i); cfg_base = b; cfg_size = s;
    cfg_rdw = WW'(rw); cfg_wrw = WW'(ww); cfg_cs = CW'(c); cfg_flag = f;
    @(posedge clk);
    #1 cfg_we = 0;
    case (op)
      0: begin
        p = 1;
        while (p < s) p = p << 1;
        m_mask[i] = ~(p - 1); m_cmp[i] = b & ~(p - 1);
        m_valid[i] = 1; m_rw[i] = 2; m_ww[i] = 2; m_cs[i] = -1;
      end
      1: begin m_rw[i] = rw; m_ww[i] = ww; m_cs[i] = c; end
      2: m_valid[i] = f;
      default: begin
        if (f) for (int k = 0; k < N; k++) m_mc[k] = (k == i);
        else m_mc[i] = 0;
      end
    endcase
  endtask

  task automatic access(input string tag, input logic [AW-1:0] a, input bit r);
    exp_t e;
    int w;
    @(negedge clk);
    req = 1; addr = a; rd = r;
    w = m_pick(a);
    e.tag = tag;
    e.hit = (w >= 0);
    e.idx = (w >= 0) ? w : 0;
    e.err = (w < 0);
    e.cs  = (w >= 0) ? m_cs[w] : 0;
    e.wt  = (w >= 0) ? (r ? m_rw[w] : m_ww[w]) : 0;
    e.deny = (w >= 0) && (e.wt < 0);
    sb.push_back(e);
    -> mon_ev;
    @(posedge clk);
    m_last_v = (w >= 0);
    m_last_i = (w >= 0) ? w : 0;
    #1 req = 0;
  endtask

  // monitor: pops expected items and compares 2 ns after they are driven
  initial begin
    forever begin
      @(mon_ev);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (hit !== e.hit || int'(idx) != e.idx || berr !== e.err ||
            int'(cs) != e.cs || int'(wt) != e.wt || deny !== e.deny) begin
          bad++;
          $display("FAIL %s: got hit=%0b idx=%0d err=%0b cs=%0d wait=%0d deny=%0b exp hit=%0b idx=%0d err=%0b cs=%0d wait=%0d deny=%0b",
                   e.tag, hit, idx, berr, cs, wt, deny,
                   e.hit, e.idx, e.err, e.cs, e.wt, e.deny);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mask[i] = '1; m_cmp[i] = '0; m_valid[i] = 0; m_mc[i] = 0;
      m_rw[i] = 2; m_ww[i] = 2; m_cs[i] = -1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset: idle, nothing matches
    @(negedge clk); #2;
    total++;
    if (hit !== 1'b0 || berr !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: got hit=%0b err=%0b exp hit=0 err=0", hit, berr);
    end
    access("R7 R11 miss after reset", 32'h0000_1234, 1);
    // R2 R3 load defaults
    cfg(0, 0, 32'h0000_1000, 32'h1000, 0, 0, 0, 0);
    access("R1 R3 r0 hit defaults", 32'h0000_1abc, 1);
    cfg(0, 2, 32'h0000_2345, 32'h300, 0, 0, 0, 0);
    access("R2 rounded top edge", 32'h0000_23ff, 1);
    access("R2 beyond rounded size", 32'h0000_2400, 1);
    access("R2 aligned bottom", 32'h0000_2000, 0);
    // R9 R10 timing and negative write wait
    cfg(1, 2, 0, 0, 5, -1, 3, 0);
    access("R9 read wait and cs", 32'h0000_2010, 1);
    access("R10 write denied", 32'h0000_2010, 0);
    // R5 R6 overlapping regions
    cfg(0, 5, 32'h0000_0000, 32'h10000, 0, 0, 0, 0);
    access("R6 only r5 covers", 32'h0000_8000, 1);
    access("R5 last hit beats lower index", 32'h0000_1100, 1);
    access("R7 R8 miss clears last", 32'h0004_0000, 1);
    access("R6 lowest valid index wins", 32'h0000_1100, 1);
    cfg(2, 0, 0, 0, 0, 0, 0, 0);
    access("R5 invalid but last hit", 32'h0000_1100, 1);
    access("R8 miss clears", 32'h0009_0000, 0);
    access("R6 invalid r0 skipped", 32'h0000_1100, 1);
    // R8 no req: last hit unchanged
    @(negedge clk); addr = 32'h0009_0000; @(posedge clk);
    access("R8 idle keeps last", 32'h0000_1100, 0);
    // R4 memory-controller region
    cfg(0, 7, 32'h0000_1000, 32'h100, 0, 0, 0, 0);
    cfg(2, 7, 0, 0, 0, 0, 0, 0);
    cfg(3, 7, 0, 0, 0, 0, 0, 1);
    access("R4 invalid mc region wins", 32'h0000_1010, 1);
    cfg(0, 6, 32'h0005_0000, 32'h10, 0, 0, 0, 0);
    cfg(3, 6, 0, 0, 0, 0, 0, 1);
    access("R4 R5 mc moved, last hit r7", 32'h0000_1010, 1);
    access("R4 new mc region", 32'h0005_0004, 1);
    access("R8 miss", 32'h0009_0000, 1);
    access("R4 old mc no longer wins", 32'h0000_1010, 1);
    cfg(3, 6, 0, 0, 0, 0, 0, 0);
    access("R4 mc cleared, table r6", 32'h0005_000f, 0);
    access("R2 size16 boundary", 32'h0005_0010, 1);
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule